// File: doc/BRIEF.md
# Utopia Cell-Level Master Receiver with Errored-Cell Discard

This block is the receive half of a single-PHY Utopia master that moves whole cells. It watches the slave's cell-available line and drives an active-low read enable. Once a start-of-cell arrives, it takes in a fixed number of 16-bit words, along with their parity bits. The block then forwards every word to a downstream cell buffer two clock cycles later. The final word of each cell carries a last marker. If the cell turned out to be bad, that final word also carries a discard flag, so the buffer can throw the whole cell away.

The cell length comes from a static configuration input that gives the size in bytes. The value is even, from 16 to 128, and the word count is half of it. A cell is bad in two cases. The first is a word whose odd parity fails while parity checking is enabled. The second is a start-of-cell that arrives before the current cell has all of its words. For each bad cell the block raises a one-cycle error strobe with a two-bit cause code. The enable is released two words before the end of a cell when the slave has nothing more to offer. It stays low when another cell is waiting, so that cell can follow back to back.

Top module: `utopia_rx_master`

## Requirements
- R1: While no cell is in progress, `ph_rd_en_n` goes low only on the clock edge after one where `ph_cell_avail` was sampled high, and it stays high after reset while `ph_cell_avail` is low.
- R2: A word is accepted on any clock edge where `ph_soc` is high or a cell is partly received. Each accepted word appears on `cb_data` with `cb_valid` high exactly two clock edges later, in arrival order.
- R3: A cell holds N = `cfg_cell_bytes`/2 words. `cb_last` is high only on the final word of each cell, and a good cell delivers exactly N words with `cb_discard` low.
- R4: When the word with index N-3 of a cell is accepted (the first word is index 0), `ph_rd_en_n` on the next edge becomes the inverse of `ph_cell_avail` sampled then. At every other point inside a cell the enable holds its value.
- R5: If the enable is still low at a cell boundary, a start-of-cell that directly follows the last word begins a new cell with no idle cycle between them.
- R6: A start-of-cell that arrives while a cell is partly received cuts that cell short. Its last received word is delivered with `cb_last` and `cb_discard` high and status bit 1 set, and the new start-of-cell begins a fresh cell.
- R7: Parity is odd over the 16 data bits plus `ph_parity`. A failing word marks its cell as errored, with status bit 0 set, only when `cfg_parity_en` is high. When `cfg_parity_en` is low, parity has no effect.
- R8: `err_pulse` is high for one cycle, together with `cb_last` and `cb_discard`, on each discarded cell. In that cycle `err_status` is nonzero and can carry both bits. Outside that cycle `err_status` is 0.
- R9: While `rst` is high, `ph_rd_en_n` is 1 and `cb_valid`, `cb_last`, `cb_discard`, `err_pulse` and `err_status` are 0.
- R10: A word presented with `ph_soc` low while no cell is in progress is ignored: nothing is delivered downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_parity_en | input | 1 | Enables the odd-parity check |
| cfg_cell_bytes | input | 8 | Cell size in bytes; even, 16 to 128; static |
| ph_cell_avail | input | 1 | Slave has a complete cell ready |
| ph_rd_en_n | output | 1 | Active-low read enable to the slave |
| ph_soc | input | 1 | Start-of-cell flag for the word on the bus |
| ph_data | input | 16 | Received word |
| ph_parity | input | 1 | Parity bit for `ph_data` |
| cb_valid | output | 1 | Downstream word valid |
| cb_data | output | 16 | Downstream word |
| cb_last | output | 1 | Final word of a cell |
| cb_discard | output | 1 | With `cb_last`: drop the whole cell |
| err_pulse | output | 1 | One-cycle errored-cell strobe |
| err_status | output | 2 | Bit 0 = parity error, bit 1 = length error |

## Verification
The bench builds the block at its only structural setting: 16-bit words and an 8-bit size input. It moves the cell size at run time across 16, 20 and 128 bytes. With 16 bytes, the release point at word N-3 comes close to both the start and the end of the cell. With 128 bytes, the 64-word count is exercised. With a short cell, a truncation of three or four words lands well before the release point, and back-to-back cells are reached from the same small size.

// File: rtl/utrx_pkg.sv
package utrx_pkg;

    localparam int UT_WORD_W = 16;
    localparam int UT_CFG_W  = 8;
    localparam int UT_IDX_W  = UT_CFG_W - 1;

    // word held between capture and judgement
    typedef struct packed {
        logic                  valid;
        logic [UT_WORD_W-1:0]  data;
        logic [UT_IDX_W-1:0]   idx;
        logic                  perr;
    } ut_word_t;

    // error cause code: bit 1 length, bit 0 parity
    typedef struct packed {
        logic len;
        logic par;
    } ut_cause_t;

    function automatic logic ut_odd_ok(input logic [UT_WORD_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

    function automatic logic [UT_IDX_W-1:0] ut_words(input logic [UT_CFG_W-1:0] bytes);
        return UT_IDX_W'(bytes >> 1);
    endfunction

endpackage

// File: rtl/utrx_enable_ctrl.sv
module utrx_enable_ctrl
    import utrx_pkg::*;
#(
    parameter int IDX_W = UT_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cell_avail,
    input  logic             bus_active,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [IDX_W-1:0] n_words,
    output logic             en_o
);

    logic en_q;
    logic en_d;

    always_comb begin
        en_d = en_q;
        if (bus_active) begin
            // decision point two words ahead of the cell's end
            if (bus_idx == n_words - IDX_W'(3)) en_d = cell_avail;
        end else if (!en_q) begin
            en_d = cell_avail;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_d;
    end

    assign en_o = en_q;

    a_r1_enable_after_avail: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(cell_avail));

    a_r4_hold_mid_cell: assert property (@(posedge clk) disable iff (rst)
        (bus_active && bus_idx != n_words - IDX_W'(3)) |=> $stable(en_q));

endmodule

// File: rtl/utrx_word_cap.sv
module utrx_word_cap
    import utrx_pkg::*;
#(
    parameter int WORD_W = UT_WORD_W,
    parameter int IDX_W  = UT_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_en,
    input  logic [IDX_W-1:0]  n_words,
    input  logic              bus_soc,
    input  logic [WORD_W-1:0] bus_data,
    input  logic              bus_par,
    output logic              bus_active,
    output logic [IDX_W-1:0]  bus_idx,
    output logic              trunc,
    output ut_word_t          s1
);

    logic [IDX_W-1:0] cnt_q;
    logic             in_cell;

    always_comb begin
        in_cell    = (cnt_q != '0);
        bus_active = bus_soc || in_cell;
        bus_idx    = bus_soc ? '0 : cnt_q;
        trunc      = bus_soc && in_cell;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            s1    <= '0;
        end else begin
            s1.valid <= bus_active;
            if (bus_active) begin
                s1.data <= bus_data;
                s1.idx  <= bus_idx;
                s1.perr <= par_en && !ut_odd_ok(bus_data, bus_par);
                cnt_q   <= (bus_idx == n_words - IDX_W'(1)) ? '0 : bus_idx + IDX_W'(1);
            end
        end
    end

    a_r2_idx_in_cell: assert property (@(posedge clk) disable iff (rst)
        s1.valid |-> (s1.idx < n_words));

    a_r6_trunc_restarts: assert property (@(posedge clk) disable iff (rst)
        trunc |=> (s1.valid && s1.idx == '0));

endmodule

// File: rtl/utrx_cell_judge.sv
module utrx_cell_judge
    import utrx_pkg::*;
#(
    parameter int WORD_W = UT_WORD_W,
    parameter int IDX_W  = UT_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_en,
    input  logic [IDX_W-1:0]  n_words,
    input  ut_word_t          s1,
    input  logic              trunc,
    output logic              cb_valid,
    output logic [WORD_W-1:0] cb_data,
    output logic              cb_last,
    output logic              cb_discard,
    output logic              err_pulse,
    output ut_cause_t         err_cause
);

    logic      perr_acc_q;
    logic      last_now;
    logic      par_bad;
    logic      bad;
    ut_cause_t cause_d;

    always_comb begin
        last_now    = s1.valid && ((s1.idx == n_words - IDX_W'(1)) || trunc);
        par_bad     = perr_acc_q | s1.perr;
        bad         = par_bad | trunc;
        cause_d.len = trunc;
        cause_d.par = par_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_valid   <= 1'b0;
            cb_data    <= '0;
            cb_last    <= 1'b0;
            cb_discard <= 1'b0;
            err_pulse  <= 1'b0;
            err_cause  <= '0;
            perr_acc_q <= 1'b0;
        end else begin
            cb_valid   <= s1.valid;
            cb_data    <= s1.data;
            cb_last    <= last_now;
            cb_discard <= last_now && bad;
            err_pulse  <= last_now && bad;
            err_cause  <= (last_now && bad) ? cause_d : '0;
            if (s1.valid) perr_acc_q <= last_now ? 1'b0 : par_bad;
        end
    end

    // verification-only word counter per delivered cell
    logic [IDX_W-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)           seen_q <= '0;
        else if (cb_valid) seen_q <= cb_last ? '0 : seen_q + IDX_W'(1);
    end

    a_r3_good_cell_length: assert property (@(posedge clk) disable iff (rst)
        (cb_valid && cb_last && !cb_discard) |-> (seen_q == n_words - IDX_W'(1)));

    a_r8_pulse_on_last: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (cb_valid && cb_last && cb_discard));

    a_r8_cause_nonzero: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_cause != '0));

    a_r8_cause_quiet: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> (err_cause == '0));

    a_r7_parity_gated: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_cause.par) |-> $past(par_en, 2));

endmodule

// File: rtl/utopia_rx_master.sv
module utopia_rx_master
    import utrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_parity_en,
    input  logic [UT_CFG_W-1:0]  cfg_cell_bytes,
    input  logic                 ph_cell_avail,
    output logic                 ph_rd_en_n,
    input  logic                 ph_soc,
    input  logic [UT_WORD_W-1:0] ph_data,
    input  logic                 ph_parity,
    output logic                 cb_valid,
    output logic [UT_WORD_W-1:0] cb_data,
    output logic                 cb_last,
    output logic                 cb_discard,
    output logic                 err_pulse,
    output logic [1:0]           err_status
);

    logic [UT_IDX_W-1:0] n_words;
    logic                bus_active;
    logic [UT_IDX_W-1:0] bus_idx;
    logic                trunc;
    logic                en;
    ut_word_t            s1;
    ut_cause_t           cause;

    assign n_words = ut_words(cfg_cell_bytes);

    utrx_word_cap #(.WORD_W(UT_WORD_W), .IDX_W(UT_IDX_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .par_en     (cfg_parity_en),
        .n_words    (n_words),
        .bus_soc    (ph_soc),
        .bus_data   (ph_data),
        .bus_par    (ph_parity),
        .bus_active (bus_active),
        .bus_idx    (bus_idx),
        .trunc      (trunc),
        .s1         (s1)
    );

    utrx_enable_ctrl #(.IDX_W(UT_IDX_W)) u_en (
        .clk        (clk),
        .rst        (rst),
        .cell_avail (ph_cell_avail),
        .bus_active (bus_active),
        .bus_idx    (bus_idx),
        .n_words    (n_words),
        .en_o       (en)
    );

    utrx_cell_judge #(.WORD_W(UT_WORD_W), .IDX_W(UT_IDX_W)) u_judge (
        .clk        (clk),
        .rst        (rst),
        .par_en     (cfg_parity_en),
        .n_words    (n_words),
        .s1         (s1),
        .trunc      (trunc),
        .cb_valid   (cb_valid),
        .cb_data    (cb_data),
        .cb_last    (cb_last),
        .cb_discard (cb_discard),
        .err_pulse  (err_pulse),
        .err_cause  (cause)
    );

    assign ph_rd_en_n = ~en;
    assign err_status = cause;

    a_r9_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (ph_rd_en_n && !cb_valid && !err_pulse));

endmodule

// File: tb/utopia_rx_master_tb_top.sv
module utopia_rx_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_parity_en = 1'b1;
    logic [7:0]  cfg_cell_bytes = 8'd16;
    logic        ph_cell_avail = 1'b0;
    logic        ph_rd_en_n;
    logic        ph_soc = 1'b0;
    logic [15:0] ph_data = '0;
    logic        ph_parity = 1'b0;
    logic        cb_valid, cb_last, cb_discard, err_pulse;
    logic [15:0] cb_data;
    logic [1:0]  err_status;

    always #2 clk = ~clk;

    utopia_rx_master dut_i (
        .clk(clk), .rst(rst), .cfg_parity_en(cfg_parity_en), .cfg_cell_bytes(cfg_cell_bytes),
        .ph_cell_avail(ph_cell_avail), .ph_rd_en_n(ph_rd_en_n), .ph_soc(ph_soc),
        .ph_data(ph_data), .ph_parity(ph_parity), .cb_valid(cb_valid), .cb_data(cb_data),
        .cb_last(cb_last), .cb_discard(cb_discard), .err_pulse(err_pulse), .err_status(err_status)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_good   = 0;
    int n_bad    = 0;
    int n_valid  = 0;
    bit saw_both = 0;
    bit cmp_on   = 0;
    bit done     = 0;

    typedef struct packed {
        logic        v;
        logic [15:0] d;
        logic        last;
        logic        disc;
        logic        err;
        logic [1:0]  st;
    } exp_t;

    exp_t exp_q[int];
    exp_t e_cur = '0;
    bit   e_en  = 0;
    int   m_cnt = 0;
    bit   m_en  = 0;
    bit   m_cpar = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // behavioural reference: tracks cells as lists of scheduled outputs
    always @(posedge clk) begin
        int   nw;
        int   idx;
        bit   pe;
        exp_t w;
        cyc++;
        if (rst) begin
            m_cnt = 0; m_en = 0; m_cpar = 0; e_en = 0; e_cur = '0;
            exp_q.delete();
        end else begin
            nw = int'(cfg_cell_bytes) / 2;
            if (ph_soc && m_cnt != 0 && exp_q.exists(cyc)) begin
                // R6: early start-of-cell closes the short cell as errored
                w = exp_q[cyc];
                w.last = 1; w.disc = 1; w.err = 1; w.st = {1'b1, m_cpar};
                exp_q[cyc] = w;
            end
            if (exp_q.exists(cyc)) begin
                e_cur = exp_q[cyc];
                exp_q.delete(cyc);
            end else begin
                e_cur = '0;
            end
            if (ph_soc || m_cnt != 0) begin
                idx = ph_soc ? 0 : m_cnt;
                pe  = cfg_parity_en && ((^ph_data) == ph_parity); // R7 odd parity fails
                m_cpar = (idx == 0) ? pe : (m_cpar | pe);
                w = '0;
                w.v = 1; w.d = ph_data; w.last = (idx == nw - 1);
                if (idx == nw - 1 && m_cpar) begin
                    w.disc = 1; w.err = 1; w.st = 2'b01;
                end
                exp_q[cyc + 1] = w;
                if (idx == nw - 3) m_en = ph_cell_avail;   // R4
                m_cnt = (idx == nw - 1) ? 0 : idx + 1;
            end else if (!m_en) begin
                m_en = ph_cell_avail;                      // R1
            end
            e_en = m_en;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk(ph_rd_en_n == !e_en, "R1/R4", "rd_en_n", ph_rd_en_n, !e_en);
            chk(cb_valid == e_cur.v, "R2", "cb_valid", cb_valid, e_cur.v);
            if (e_cur.v) begin
                chk(cb_data == e_cur.d, "R2", "cb_data", cb_data, e_cur.d);
                chk(cb_last == e_cur.last, "R3", "cb_last", cb_last, e_cur.last);
                chk(cb_discard == e_cur.disc, "R6", "cb_discard", cb_discard, e_cur.disc);
            end
            chk(err_pulse == e_cur.err, "R8", "err_pulse", err_pulse, e_cur.err);
            chk(err_status == e_cur.st, "R8", "err_status", err_status, e_cur.st);
            if (cb_valid) n_valid++;
            if (cb_valid && cb_last) begin
                if (cb_discard) n_bad++; else n_good++;
            end
            if (err_pulse && err_status == 2'b11) saw_both = 1;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_en();
        for (int k = 0; k < 60 && ph_rd_en_n !== 1'b0; k++) tick();
        chk(ph_rd_en_n === 1'b0, "R1", "enable never asserted", ph_rd_en_n, 0);
    endtask

    task automatic send_cell(input int nw, input int bad_at, input bit drop, input int base);
        for (int k = 0; k < nw; k++) begin
            ph_soc    = (k == 0);
            ph_data   = 16'(base + k * 37);
            ph_parity = ~(^ph_data);
            if (k == bad_at) ph_parity = ~ph_parity;
            if (k == 0 && drop) ph_cell_avail = 1'b0;
            tick();
        end
        ph_soc = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        int v0;
        repeat (3) tick();
        // R9: reset state
        chk(ph_rd_en_n == 1'b1, "R9", "rd_en_n in reset", ph_rd_en_n, 1);
        chk(cb_valid == 1'b0, "R9", "cb_valid in reset", cb_valid, 0);
        chk(err_pulse == 1'b0 && err_status == 2'b00, "R9", "error in reset", err_status, 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R10: stray words without a start-of-cell, no cell available
        v0 = n_valid;
        for (int k = 0; k < 5; k++) begin
            ph_data = 16'h1234 + 16'(k);
            ph_parity = ~(^ph_data);
            tick();
        end
        idle(3);
        chk(n_valid == v0, "R10", "words delivered from stray input", n_valid - v0, 0);
        chk(ph_rd_en_n == 1'b1, "R1", "enable without avail", ph_rd_en_n, 1);

        // R3/R4: single good cell, slave has nothing further
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(8, -1, 1, 16'h0100);
        idle(6);

        // R5: back-to-back cells
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(8, -1, 0, 16'h0200);
        chk(ph_rd_en_n == 1'b0, "R5", "enable held at boundary", ph_rd_en_n, 0);
        send_cell(8, -1, 1, 16'h0300);
        idle(6);

        // R7: parity error with checking on
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(8, 3, 1, 16'h0400);
        idle(6);

        // R7: same bad parity with checking off has no effect
        cfg_parity_en = 1'b0;
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(8, 3, 1, 16'h0500);
        idle(6);
        cfg_parity_en = 1'b1;

        // R6: short cell cut by early start-of-cell
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(3, -1, 0, 16'h0600);
        send_cell(8, -1, 1, 16'h0700);
        idle(6);

        // R8: short cell that also has a parity error
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(4, 1, 0, 16'h0800);
        send_cell(8, -1, 1, 16'h0900);
        idle(6);

        // R3: other cell sizes
        cfg_cell_bytes = 8'd20;
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(10, -1, 1, 16'h0A00);
        idle(6);
        cfg_cell_bytes = 8'd128;
        ph_cell_avail = 1'b1;
        wait_en();
        send_cell(64, -1, 1, 16'h0B00);
        idle(6);

        chk(n_good == 8, "R3", "good cells delivered", n_good, 8);
        chk(n_bad == 3, "R6", "discarded cells", n_bad, 3);
        chk(saw_both == 1'b1, "R8", "both status bits together", saw_both, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule